// File: doc/BRIEF.md
# Three-Channel Line-Scheduled DMA Instruction Sequencer

The block runs three small instruction streams, one per channel, from a shared memory. It paces itself by the horizontal sync of the video timing. Once per scan line, after hsync rises, it leaves one cycle idle. It then gives channel 0, channel 1 and channel 2, in that order, one slot each. In its slot, a channel that is enabled and not paused fetches one 16-bit instruction from its own even-aligned pointer. It then carries out that instruction.

Every instruction holds a function nibble in bits 15:12 and an operand in bits 11:0. An instruction whose nibble has bits 2:0 all zero sends an 8-bit value to a 4-bit target register index on the register-write bus; a downstream sound generator consumes that bus. Any other nibble selects a control action, a repeat count or a pause measured in lines. Control actions can loop back to a repeat point, raise an interrupt or stop the channel.

A CPU-side status register holds the three channel enables, the three channel interrupt flags and a raster interrupt flag. The interrupt output is high whenever any flag is set. A separate pointer-load port places a new instruction address in any channel.

Top module: `dma_seq_top`

## Requirements
- R1: The sequence starts from the clock edge that first samples hsync high while the sequencer is idle. mem_req for channel 0 rises on the third clock edge, counting that edge as the first. Channel slots follow in the order 0, 1, 2, and each slot spends one decision cycle before any fetch.
- R2: On each line, every enabled channel that is not paused makes exactly one fetch, and other channels make none. mem_req holds high with a stable mem_addr until mem_ack. A new rising edge of hsync before the current line's slots are finished starts no extra sequence.
- R3: A channel's fetch address is its pointer, which is always even. A pointer load stores ptr_wdata with bit 0 cleared. The pointer steps by 2 after every fetch unless a taken loop replaces it.
- R4: Function nibble is instr[15:12]. When instr[14:12] is 000, reg_we pulses for one cycle in the cycle after the mem_ack cycle, with reg_idx = instr[11:8] and reg_data = instr[7:0]. Bit 15 has no effect on any decode.
- R5: Exactly one action is taken per instruction, with priority nibble bit 2 (control), then bit 1 (repeat), then bit 0 (pause).
- R6: A pause with operand N makes the channel skip its slot on the next N lines while it remains enabled. N = 0 skips nothing.
- R7: A repeat with operand N records the address after it as the loop start and N as the loop count. A control instruction with operand bit 0 set jumps to the loop start and decrements the count while the count is non-zero. Otherwise it falls through, so the loop body runs N+1 times.
- R8: Control operand bit 4 sets the channel's interrupt flag, and control operand bit 5 clears the channel's enable bit. A control instruction with neither bit 4 nor bit 5 set and bit 0 clear does nothing beyond advancing the pointer.
- R9: Status register layout: bits 2, 1 and 0 are the enables of channels 2, 1 and 0, and a write loads them directly. Bits 6, 5 and 4 are the flags of channels 0, 1 and 2. Bit 7 is the raster flag, set by raster_hit. Bit 3 reads 0. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A flag set in the same cycle as its clear stays set.
- R10: irq is high exactly when any of status bits 7:4 is set.
- R11: After reset, the status register reads 0, irq is low, and mem_req and reg_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync; a rising edge starts a line's slots |
| mem_req | output | 1 | Instruction fetch request |
| mem_addr | output | AW | Byte address of the fetch, always even |
| mem_ack | input | 1 | Fetch acknowledge; mem_rdata is valid with it |
| mem_rdata | input | 16 | Fetched instruction |
| reg_we | output | 1 | Register-write strobe |
| reg_idx | output | 4 | Target register index |
| reg_data | output | 8 | Value written to the target register |
| csr_we | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rdata | output | 8 | Status register contents |
| ptr_we | input | 1 | Pointer load strobe |
| ptr_sel | input | 2 | Channel selected for the pointer load |
| ptr_wdata | input | AW | Pointer value to load |
| raster_hit | input | 1 | Sets the raster interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The first fetch request is due on the third clock edge after hsync is first seen high; the bench counts samples from its hsync drive and expects exactly that number. Each register write must appear in the cycle right after the fetch's acknowledge cycle. The monitor carries a one-sample "write due" flag computed from the acknowledged word, and compares it with reg_we at the next sample. Status and interrupt effects of an instruction appear one cycle after its acknowledge. The bench reads them only after the full line has settled, about thirty cycles later. A scoreboard queue of expected fetch addresses and write pairs, filled in program order, is checked at every handshake, and each line's fetch count is compared with the count the requirements predict.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int NUM_CH      = 3;
    localparam int CH_W        = 2;
    localparam int INSTR_W     = 16;
    localparam int OPND_W      = 12;
    localparam int REG_IDX_W   = 4;
    localparam int REG_DAT_W   = 8;
    localparam int CSR_W       = 8;
    localparam int CSR_RAST_BIT = 7;
    localparam int CSR_FLAG_TOP = 6;
    localparam int CTRL_LOOP_BIT = 0;
    localparam int CTRL_IRQ_BIT  = 4;
    localparam int CTRL_STOP_BIT = 5;

    typedef enum logic [1:0] {
        SQ_WAIT,
        SQ_DEAD,
        SQ_SLOT,
        SQ_FETCH
    } sq_state_e;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_PAUSE,
        OP_REPEAT,
        OP_CTRL
    } op_kind_e;

    function automatic op_kind_e decode_kind(input logic [2:0] fn);
        if (fn[2])      return OP_CTRL;
        else if (fn[1]) return OP_REPEAT;
        else if (fn[0]) return OP_PAUSE;
        return OP_WRITE;
    endfunction
endpackage

// File: rtl/dma_seq_sched.sv
module dma_seq_sched
    import dma_seq_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsync,
    input  logic                mem_ack,
    input  logic [NCH-1:0]      ch_ready,
    output logic                mem_req,
    output logic [CH_W-1:0]     cur_ch,
    output logic [NCH-1:0]      fetch_done,
    output logic [NCH-1:0]      skip_slot
);
    typedef struct packed {
        sq_state_e       state;
        logic [CH_W-1:0] ch;
        logic            hs_prev;
    } sched_t;

    sched_t q, d;

    always_comb begin
        d          = q;
        d.hs_prev  = hsync;
        fetch_done = '0;
        skip_slot  = '0;
        case (q.state)
            SQ_WAIT: begin
                if (hsync && !q.hs_prev) begin
                    d.state = SQ_DEAD;
                end
            end
            SQ_DEAD: begin
                d.state = SQ_SLOT;
                d.ch    = '0;
            end
            SQ_SLOT: begin
                if (ch_ready[q.ch]) begin
                    d.state = SQ_FETCH;
                end else begin
                    skip_slot[q.ch] = 1'b1;
                    if (q.ch == CH_W'(NCH - 1)) begin
                        d.state = SQ_WAIT;
                    end else begin
                        d.ch = q.ch + CH_W'(1);
                    end
                end
            end
            default: begin
                if (mem_ack) begin
                    fetch_done[q.ch] = 1'b1;
                    if (q.ch == CH_W'(NCH - 1)) begin
                        d.state = SQ_WAIT;
                    end else begin
                        d.ch    = q.ch + CH_W'(1);
                        d.state = SQ_SLOT;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: SQ_WAIT, ch: '0, hs_prev: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mem_req = (q.state == SQ_FETCH);
    assign cur_ch  = q.ch;
endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
    import dma_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 ptr_ld,
    input  logic [AW-1:0]        ptr_val,
    input  logic                 fetch_done,
    input  logic                 skip_slot,
    input  logic [INSTR_W-1:0]   instr,
    output logic [AW-1:0]        ptr,
    output logic                 ready,
    output logic                 wr_v,
    output logic [REG_IDX_W-1:0] wr_idx,
    output logic [REG_DAT_W-1:0] wr_dat,
    output logic                 irq_ev,
    output logic                 stop_ev
);
    typedef struct packed {
        logic [AW-1:0]        ptr;
        logic [AW-1:0]        loop_ptr;
        logic [OPND_W-1:0]    loop_cnt;
        logic [OPND_W-1:0]    pause_cnt;
        logic                 wr_v;
        logic [REG_IDX_W-1:0] wr_idx;
        logic [REG_DAT_W-1:0] wr_dat;
    } chan_t;

    chan_t q, d;
    op_kind_e          kind;
    logic [OPND_W-1:0] opnd;
    logic [AW-1:0]     step;
    logic              unused_bits;

    assign unused_bits = instr[INSTR_W-1] ^ ptr_val[0];
    assign kind = decode_kind(instr[INSTR_W-2:OPND_W]);
    assign opnd = instr[OPND_W-1:0];
    assign step = q.ptr + AW'(2);

    always_comb begin
        d       = q;
        d.wr_v  = 1'b0;
        irq_ev  = 1'b0;
        stop_ev = 1'b0;
        if (fetch_done) begin
            d.ptr = step;
            case (kind)
                OP_WRITE: begin
                    d.wr_v   = 1'b1;
                    d.wr_idx = opnd[OPND_W-1 -: REG_IDX_W];
                    d.wr_dat = opnd[REG_DAT_W-1:0];
                end
                OP_PAUSE: begin
                    d.pause_cnt = opnd;
                end
                OP_REPEAT: begin
                    d.loop_ptr = step;
                    d.loop_cnt = opnd;
                end
                default: begin
                    if (opnd[CTRL_LOOP_BIT] && (q.loop_cnt != '0)) begin
                        d.loop_cnt = q.loop_cnt - OPND_W'(1);
                        d.ptr      = q.loop_ptr;
                    end
                    irq_ev  = opnd[CTRL_IRQ_BIT];
                    stop_ev = opnd[CTRL_STOP_BIT];
                end
            endcase
        end else if (skip_slot && en && (q.pause_cnt != '0)) begin
            d.pause_cnt = q.pause_cnt - OPND_W'(1);
        end
        if (ptr_ld) begin
            d.ptr = {ptr_val[AW-1:1], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ptr    = q.ptr;
    assign ready  = (q.pause_cnt == '0);
    assign wr_v   = q.wr_v;
    assign wr_idx = q.wr_idx;
    assign wr_dat = q.wr_dat;
endmodule

// File: rtl/dma_seq_csr.sv
module dma_seq_csr
    import dma_seq_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic [NCH-1:0]   stop_ev,
    input  logic [NCH-1:0]   irq_ev,
    input  logic             raster_hit,
    output logic [NCH-1:0]   en,
    output logic [CSR_W-1:0] csr_rdata,
    output logic             irq
);
    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] flag;
        logic           rast;
    } csr_t;

    csr_t q, d;
    logic unused_gap;

    assign unused_gap = csr_wdata[NCH];

    always_comb begin
        d = q;
        if (csr_we) begin
            d.en = csr_wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (csr_wdata[CSR_FLAG_TOP - i]) d.flag[i] = 1'b0;
            end
            if (csr_wdata[CSR_RAST_BIT]) d.rast = 1'b0;
        end
        for (int i = 0; i < NCH; i++) begin
            if (stop_ev[i] && !csr_we) d.en[i] = 1'b0;
            if (irq_ev[i]) d.flag[i] = 1'b1;
        end
        if (raster_hit) d.rast = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        csr_rdata = '0;
        csr_rdata[NCH-1:0] = q.en;
        for (int i = 0; i < NCH; i++) begin
            csr_rdata[CSR_FLAG_TOP - i] = q.flag[i];
        end
        csr_rdata[CSR_RAST_BIT] = q.rast;
    end

    assign en  = q.en;
    assign irq = (|q.flag) | q.rast;
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
    import dma_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsync,
    output logic                 mem_req,
    output logic [AW-1:0]        mem_addr,
    input  logic                 mem_ack,
    input  logic [INSTR_W-1:0]   mem_rdata,
    output logic                 reg_we,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [REG_DAT_W-1:0] reg_data,
    input  logic                 csr_we,
    input  logic [CSR_W-1:0]     csr_wdata,
    output logic [CSR_W-1:0]     csr_rdata,
    input  logic                 ptr_we,
    input  logic [CH_W-1:0]      ptr_sel,
    input  logic [AW-1:0]        ptr_wdata,
    input  logic                 raster_hit,
    output logic                 irq
);
    logic [NUM_CH-1:0]    ch_en;
    logic [NUM_CH-1:0]    ch_ready;
    logic [NUM_CH-1:0]    ch_go;
    logic [NUM_CH-1:0]    fetch_done;
    logic [NUM_CH-1:0]    skip_slot;
    logic [NUM_CH-1:0]    irq_ev;
    logic [NUM_CH-1:0]    stop_ev;
    logic [NUM_CH-1:0]    wr_v;
    logic [CH_W-1:0]      cur_ch;
    logic [AW-1:0]        ch_ptr [NUM_CH];
    logic [REG_IDX_W-1:0] wr_idx [NUM_CH];
    logic [REG_DAT_W-1:0] wr_dat [NUM_CH];

    assign ch_go = ch_en & ch_ready;

    dma_seq_sched #(.NCH(NUM_CH)) i_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .mem_ack    (mem_ack),
        .ch_ready   (ch_go),
        .mem_req    (mem_req),
        .cur_ch     (cur_ch),
        .fetch_done (fetch_done),
        .skip_slot  (skip_slot)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dma_seq_chan #(.AW(AW)) i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (ch_en[g]),
            .ptr_ld     (ptr_we && (ptr_sel == CH_W'(g))),
            .ptr_val    (ptr_wdata),
            .fetch_done (fetch_done[g]),
            .skip_slot  (skip_slot[g]),
            .instr      (mem_rdata),
            .ptr        (ch_ptr[g]),
            .ready      (ch_ready[g]),
            .wr_v       (wr_v[g]),
            .wr_idx     (wr_idx[g]),
            .wr_dat     (wr_dat[g]),
            .irq_ev     (irq_ev[g]),
            .stop_ev    (stop_ev[g])
        );
    end

    dma_seq_csr #(.NCH(NUM_CH)) i_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_we     (csr_we),
        .csr_wdata  (csr_wdata),
        .stop_ev    (stop_ev),
        .irq_ev     (irq_ev),
        .raster_hit (raster_hit),
        .en         (ch_en),
        .csr_rdata  (csr_rdata),
        .irq        (irq)
    );

    always_comb begin
        mem_addr = '0;
        reg_we   = 1'b0;
        reg_idx  = '0;
        reg_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cur_ch == CH_W'(i)) mem_addr = ch_ptr[i];
            if (wr_v[i]) begin
                reg_we   = 1'b1;
                reg_idx  = wr_idx[i];
                reg_data = wr_dat[i];
            end
        end
    end
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          reg_we,
    input logic [7:0]    csr_rdata,
    input logic          irq
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // R3
    even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    // R4
    wr_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(mem_req && mem_ack));

    // R10
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr_rdata[7:4] != 4'b0000));

    // R10
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (csr_rdata[7:4] == 4'b0000));
endmodule

bind dma_seq_top dma_seq_chk #(.AW(AW)) i_dma_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .reg_we    (reg_we),
    .csr_rdata (csr_rdata),
    .irq       (irq)
);

// File: tb/test_dma_seq_top.sv
module test_dma_seq_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        reg_we;
    logic [3:0]  reg_idx;
    logic [7:0]  reg_data;
    logic        csr_we = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic        ptr_we = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic [15:0] ptr_wdata = '0;
    logic        raster_hit = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int fetch_count = 0;
    bit finished = 1'b0;
    bit wr_due = 1'b0;
    logic [15:0] mem [256];
    logic [15:0] exp_addr [$];
    logic [11:0] exp_wr [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_seq_top i_dma_seq_top (
        .clk(clk), .rst_n(rst_n), .hsync(hsync),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_data(reg_data),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
        .raster_hit(raster_hit), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder: acknowledges one cycle after the request is seen
    always @(negedge clk) begin
        mem_ack   <= mem_req && !mem_ack;
        mem_rdata <= mem[mem_addr[8:1]];
    end

    // monitor: compares handshakes and register writes against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R4 reg_we timing", {31'd0, reg_we}, {31'd0, wr_due});
            if (reg_we) begin
                if (exp_wr.size() == 0) chk("R4 unexpected write", {20'd0, reg_idx, reg_data}, 32'hFFFF);
                else chk("R4 write idx/data", {20'd0, reg_idx, reg_data}, {20'd0, exp_wr.pop_front()});
            end
            wr_due = 1'b0;
            if (mem_req && mem_ack) begin
                fetch_count++;
                if (exp_addr.size() == 0) chk("R2 unexpected fetch", {16'd0, mem_addr}, 32'hFFFF);
                else chk("R3 fetch address", {16'd0, mem_addr}, {16'd0, exp_addr.pop_front()});
                wr_due = (mem_rdata[14:12] == 3'b000);
            end
        end
    end

    task automatic push_fetch(input logic [15:0] a);
        exp_addr.push_back(a);
    endtask

    task automatic push_wr(input logic [3:0] idx, input logic [7:0] dat);
        exp_wr.push_back({idx, dat});
    endtask

    task automatic ld_ptr(input logic [1:0] s, input logic [15:0] a);
        @(negedge clk); ptr_we = 1'b1; ptr_sel = s; ptr_wdata = a;
        @(negedge clk); ptr_we = 1'b0;
    endtask

    task automatic csr_wr(input logic [7:0] v);
        @(negedge clk); csr_we = 1'b1; csr_wdata = v;
        @(negedge clk); csr_we = 1'b0; #1;
    endtask

    task automatic run_line(input int exp_n, input bit chk_lat, input bit glitch);
        int n;
        int base;
        base = fetch_count;
        @(negedge clk); hsync = 1'b1;
        n = 0;
        do begin
            @(negedge clk); #1; n++;
            if (glitch && n == 1) hsync = 1'b0;
            if (glitch && n == 2) hsync = 1'b1;
        end while (!mem_req && n < 12);
        if (chk_lat) chk("R1 first request delay", n, 3);
        repeat (4) @(negedge clk);
        hsync = 1'b0;
        repeat (30) @(negedge clk);
        #1;
        chk("R2 fetches in line", fetch_count - base, exp_n);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        // channel 0 at 0x0000
        mem[0] = 16'h0111; mem[1] = 16'h2002; mem[2] = 16'h0222; mem[3] = 16'h4001;
        mem[4] = 16'h4010; mem[5] = 16'h1001; mem[6] = 16'h8333; mem[7] = 16'h4020;
        // channel 1 at 0x0080, later 0x0090
        mem[64] = 16'h0A5C; mem[65] = 16'h4030;
        mem[72] = 16'h3005; mem[73] = 16'h7010; mem[74] = 16'h4020;
        // channel 2 at 0x0100
        mem[128] = 16'h4000; mem[129] = 16'h1000; mem[130] = 16'h0F7E; mem[131] = 16'h4020;

        repeat (3) @(negedge clk);
        #1;
        chk("R11 csr after reset", csr_rdata, 8'h00);
        chk("R11 irq after reset", irq, 1'b0);
        chk("R11 mem_req after reset", mem_req, 1'b0);
        chk("R11 reg_we after reset", reg_we, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        ld_ptr(2'd0, 16'h0000);
        ld_ptr(2'd1, 16'h0080);
        ld_ptr(2'd2, 16'h0101);   // R3: bit 0 dropped
        csr_wr(8'h07);
        chk("R9 enables written", csr_rdata, 8'h07);

        push_fetch(16'h0000); push_fetch(16'h0080); push_fetch(16'h0100);
        push_wr(4'h1, 8'h11); push_wr(4'hA, 8'h5C);
        run_line(3, 1'b1, 1'b0);

        push_fetch(16'h0002); push_fetch(16'h0082); push_fetch(16'h0102);
        run_line(3, 1'b0, 1'b0);
        chk("R8 ch1 irq+stop status", csr_rdata, 8'h25);
        chk("R10 irq raised", irq, 1'b1);
        csr_wr(8'h25);
        chk("R9 write-one clears flag", csr_rdata, 8'h05);
        chk("R10 irq dropped", irq, 1'b0);

        push_fetch(16'h0004); push_fetch(16'h0104);
        push_wr(4'h2, 8'h22); push_wr(4'hF, 8'h7E);
        run_line(2, 1'b0, 1'b0);   // R6: pause 0 skips nothing

        push_fetch(16'h0006); push_fetch(16'h0106);
        run_line(2, 1'b0, 1'b0);
        chk("R8 ch2 stopped", csr_rdata, 8'h01);

        push_fetch(16'h0004); push_wr(4'h2, 8'h22);
        run_line(1, 1'b0, 1'b1);   // R2: second hsync edge mid-line ignored
        push_fetch(16'h0006);
        run_line(1, 1'b0, 1'b0);
        push_fetch(16'h0004); push_wr(4'h2, 8'h22);
        run_line(1, 1'b0, 1'b0);
        push_fetch(16'h0006);
        run_line(1, 1'b0, 1'b0);   // R7: loop exhausted, falls through
        push_fetch(16'h0008);
        run_line(1, 1'b0, 1'b0);
        chk("R8 ch0 irq flag", csr_rdata, 8'h41);
        chk("R10 irq for ch0", irq, 1'b1);
        push_fetch(16'h000A);
        run_line(1, 1'b0, 1'b0);
        run_line(0, 1'b0, 1'b0);   // R6: one line skipped
        push_fetch(16'h000C); push_wr(4'h3, 8'h33);   // R4: bit 15 ignored
        run_line(1, 1'b0, 1'b0);
        push_fetch(16'h000E);
        run_line(1, 1'b0, 1'b0);
        chk("R8 ch0 stopped", csr_rdata, 8'h40);
        run_line(0, 1'b0, 1'b0);

        @(negedge clk); raster_hit = 1'b1;
        @(negedge clk); raster_hit = 1'b0; #1;
        chk("R9 raster flag set", csr_rdata, 8'hC0);
        csr_wr(8'h80);
        chk("R9 clear raster only", csr_rdata, 8'h40);
        @(negedge clk); raster_hit = 1'b1; csr_we = 1'b1; csr_wdata = 8'h80;
        @(negedge clk); raster_hit = 1'b0; csr_we = 1'b0; #1;
        chk("R9 set beats clear", csr_rdata, 8'hC0);
        csr_wr(8'hC0);
        chk("R9 all flags cleared", csr_rdata, 8'h00);
        chk("R10 irq low", irq, 1'b0);

        ld_ptr(2'd1, 16'h0090);
        csr_wr(8'h02);
        push_fetch(16'h0090);
        run_line(1, 1'b0, 1'b0);
        push_fetch(16'h0092);
        run_line(1, 1'b0, 1'b0);   // R5: repeat beat pause, no skipped line
        chk("R5 control beats pause", csr_rdata, 8'h22);
        push_fetch(16'h0094);
        run_line(1, 1'b0, 1'b0);
        chk("R8 ch1 stopped again", csr_rdata, 8'h20);

        chk("R2 address queue drained", exp_addr.size(), 0);
        chk("R4 write queue drained", exp_wr.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule